// File: doc/BRIEF.md
# Receive Flow Control Hysteresis Comparator

This block drives an active-low request-to-send line so that a receiver can throttle its sender on its own. The fill level of a receive FIFO is compared with a programmable trigger level. A hysteresis band is placed evenly on both sides of that trigger. When the fill level climbs to the top of the band, the line goes high and asks the sender to pause. When the fill level drains to the bottom of the band, the line goes low again. Between the two edges of the band the line keeps its last value, so it does not chatter.

The width of the band is picked from a fixed, non-linear list of sixteen character counts. A 4-bit selector indexes the list. The selector is formed from two extended mode bits and two FIFO control bits. When automatic control is switched off, the line follows a software request bit. The output is registered and changes on the clock edge after its inputs.

Top module: `rts_hyst_ctrl`

## Requirements
- R1: While reset is asserted, and after its release until the first clock edge, rts_n is 0 (asserted).
- R2: With auto_en = 0, rts_n after each clock edge equals the inverse of sw_rts sampled at that edge.
- R3: With auto_en = 1, rts_n becomes 1 after an edge at which rx_count >= HI, where HI = min(trig_lvl + H, DEPTH) and H is the selected hysteresis.
- R4: With auto_en = 1, rts_n becomes 0 after an edge at which rx_count < HI and rx_count <= LO, where LO = max(trig_lvl - H, 0).
- R5: With auto_en = 1 and LO < rx_count < HI, rts_n keeps its previous value.
- R6: Selector values 0 to 3 give H = 0, 4, 6 and 8 characters.
- R7: Selector values 4 to 7 give H = 8, 16, 24 and 32 characters.
- R8: Selector values 8 to 11 give H = 40, 44, 48 and 52 characters.
- R9: Selector values 12 to 15 give H = 12, 20, 28 and 36 characters.
- R10: HI saturates at DEPTH (128 by default) and LO saturates at 0.
- R11: The selector is {ext_hyst[1], ext_hyst[0], fifo_hyst[1], fifo_hyst[0]}, with ext_hyst as the most significant pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | 1 selects automatic hysteresis control |
| sw_rts | input | 1 | Software request; 1 drives rts_n low when auto_en = 0 |
| rx_count | input | CW (8) | Receive FIFO fill level, 0 to DEPTH |
| trig_lvl | input | CW (8) | Trigger level, 0 to DEPTH |
| ext_hyst | input | 2 | Upper two bits of the hysteresis selector |
| fifo_hyst | input | 2 | Lower two bits of the hysteresis selector |
| rts_n | output | 1 | Active-low request to send |

## Verification
The assertions assume that rx_count and trig_lvl never go above DEPTH, because a FIFO cannot hold more than it has room for. They also assume that every input is stable around the sampling edge. The bench draws random fill levels and trigger levels only within 0 to DEPTH. It drives all inputs on the falling edge. Directed sweeps place the fill level exactly on the band edges and one step inside them for every selector value, and at both saturation points.

// File: rtl/rts_hyst_ctrl.sv
module rts_hyst_ctrl #(
  parameter int DEPTH = 128,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auto_en,
  input  logic          sw_rts,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] trig_lvl,
  input  logic [1:0]    ext_hyst,
  input  logic [1:0]    fifo_hyst,
  output logic          rts_n
);
  localparam int HW = 6;

  logic [3:0]    sel;
  logic [HW-1:0] hyst;
  logic [CW:0]   sum, cap, hi_thr;
  logic [CW-1:0] lo_thr;
  logic          go_high, go_low;

  assign sel = {ext_hyst, fifo_hyst};

  always_comb begin
    case (sel)
      4'd0:    hyst = 6'd0;
      4'd1:    hyst = 6'd4;
      4'd2:    hyst = 6'd6;
      4'd3:    hyst = 6'd8;
      4'd4:    hyst = 6'd8;
      4'd5:    hyst = 6'd16;
      4'd6:    hyst = 6'd24;
      4'd7:    hyst = 6'd32;
      4'd8:    hyst = 6'd40;
      4'd9:    hyst = 6'd44;
      4'd10:   hyst = 6'd48;
      4'd11:   hyst = 6'd52;
      4'd12:   hyst = 6'd12;
      4'd13:   hyst = 6'd20;
      4'd14:   hyst = 6'd28;
      default: hyst = 6'd36;
    endcase
  end

  assign sum    = {1'b0, trig_lvl} + (CW+1)'(hyst);
  assign cap    = (CW+1)'(DEPTH);
  assign hi_thr = (sum > cap) ? cap : sum;
  assign lo_thr = (trig_lvl > CW'(hyst)) ? (trig_lvl - CW'(hyst)) : '0;

  assign go_high = ({1'b0, rx_count} >= hi_thr);
  assign go_low  = !go_high && (rx_count <= lo_thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rts_n <= 1'b0;
    else if (!auto_en) rts_n <= !sw_rts;
    else if (go_high)  rts_n <= 1'b1;
    else if (go_low)   rts_n <= 1'b0;
  end
endmodule

// File: rtl/rts_hyst_chk.sv
module rts_hyst_chk #(
  parameter int DEPTH = 128,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          auto_en,
  input logic          sw_rts,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] trig_lvl,
  input logic [1:0]    ext_hyst,
  input logic [1:0]    fifo_hyst,
  input logic          rts_n
);
  int h, hi_i, lo_i, cnt_i;

  always_comb begin
    unique case (ext_hyst)
      2'b00: h = (fifo_hyst == 2'd0) ? 0 : 2 + 2 * int'(fifo_hyst);
      2'b01: h = 8 * (int'(fifo_hyst) + 1);
      2'b10: h = 40 + 4 * int'(fifo_hyst);
      default: h = 12 + 8 * int'(fifo_hyst);
    endcase
    hi_i  = int'(trig_lvl) + h;
    if (hi_i > DEPTH) hi_i = DEPTH;
    lo_i  = int'(trig_lvl) - h;
    if (lo_i < 0) lo_i = 0;
    cnt_i = int'(rx_count);
  end

  a_r1_reset_low: assert property (@(posedge clk) !rst_n |-> !rts_n);

  a_r2_manual: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(auto_en) |-> rts_n == !$past(sw_rts));

  a_r3_deassert: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(auto_en) && ($past(cnt_i) >= $past(hi_i)) |-> rts_n);

  a_r4_reassert: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(auto_en) && ($past(cnt_i) < $past(hi_i)) &&
    ($past(cnt_i) <= $past(lo_i)) |-> !rts_n);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(auto_en) && ($past(cnt_i) < $past(hi_i)) &&
    ($past(cnt_i) > $past(lo_i)) |-> $stable(rts_n));
endmodule

bind rts_hyst_ctrl rts_hyst_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (.*);

// File: tb/sim_rts_hyst_ctrl.sv
`timescale 1ns/1ps
module sim_rts_hyst_ctrl;
  localparam int DEPTH = 128;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_en = 1'b0, sw_rts = 1'b0;
  logic [CW-1:0] rx_count = '0, trig_lvl = '0;
  logic [1:0] ext_hyst = '0, fifo_hyst = '0;
  logic rts_n;
  logic exp_q = 1'b0;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rts_hyst_ctrl #(.DEPTH(DEPTH)) u0 (.*);

  function automatic int hyst_of(input logic [3:0] s);
    int t[16] = '{0,4,6,8, 8,16,24,32, 40,44,48,52, 12,20,28,36};
    return t[s];
  endfunction

  function automatic int hi_of(input int tr, input int hh);
    return (tr + hh > DEPTH) ? DEPTH : tr + hh;
  endfunction

  function automatic int lo_of(input int tr, input int hh);
    return (tr - hh < 0) ? 0 : tr - hh;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rts_n=%b expected %b (cnt=%0d trig=%0d sel=%b)",
               tag, act, exp, rx_count, trig_lvl, {ext_hyst, fifo_hyst});
    end
  endtask

  // inputs are set at the falling edge; the model advances at the rising edge
  task automatic step(input string tag);
    int hh, hi, lo;
    @(posedge clk);
    hh = hyst_of({ext_hyst, fifo_hyst});
    hi = hi_of(int'(trig_lvl), hh);
    lo = lo_of(int'(trig_lvl), hh);
    if (!auto_en) exp_q = !sw_rts;
    else if (int'(rx_count) >= hi) exp_q = 1'b1;
    else if (int'(rx_count) <= lo) exp_q = 1'b0;
    #1 check(tag, rts_n, exp_q);
    @(negedge clk);
  endtask

  task automatic set_in(input logic ae, input logic sw, input int cnt, input int tr, input logic [3:0] s);
    auto_en = ae; sw_rts = sw;
    rx_count = CW'(cnt); trig_lvl = CW'(tr);
    {ext_hyst, fifo_hyst} = s;
  endtask

  function automatic string row_tag(input logic [3:0] s);
    case (s[3:2])
      2'b00: return "R6";
      2'b01: return "R7";
      2'b10: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    set_in(1'b0, 1'b0, 0, 0, 4'd0);
    repeat (3) @(posedge clk);
    #1 check("R1", rts_n, 1'b0);
    @(negedge clk);
    set_in(1'b0, 1'b0, 100, 10, 4'd0);
    rst_n = 1'b1;
    #1 check("R1", rts_n, 1'b0);

    // R2: manual control
    step("R2");
    sw_rts = 1'b1; step("R2");
    sw_rts = 1'b0; step("R2");
    sw_rts = 1'b1; step("R2");

    // R3..R9: band edges for every selector
    for (int s = 0; s < 16; s++) begin
      int hh;
      string t;
      hh = hyst_of(4'(s));
      t = row_tag(4'(s));
      set_in(1'b1, 1'b0, 0, 64, 4'(s));      step("R4");
      rx_count = CW'(64 + hh - 1);           step({t, " R5"});
      rx_count = CW'(64 + hh);               step({t, " R3"});
      rx_count = CW'(64 - hh + 1);           step({t, " R5"});
      rx_count = CW'(64 - hh);               step({t, " R4"});
    end

    // R11: selector bit order
    set_in(1'b1, 1'b0, 0, 64, 4'b0100);      step("R11");
    rx_count = CW'(68);                       step("R11");
    {ext_hyst, fifo_hyst} = 4'b0001;          step("R11");

    // R10: saturation at both ends
    set_in(1'b1, 1'b0, 0, 100, 4'b1011);     step("R10");
    rx_count = CW'(127);                      step("R10");
    rx_count = CW'(128);                      step("R10");
    set_in(1'b1, 1'b0, 1, 20, 4'b1000);      step("R10");
    rx_count = CW'(0);                        step("R10");

    // random walk
    for (int i = 0; i < 4000; i++) begin
      int c;
      if ($urandom_range(0, 49) == 0) auto_en = ~auto_en;
      if ($urandom_range(0, 3) == 0) sw_rts = 1'($urandom);
      if ($urandom_range(0, 99) == 0) trig_lvl = CW'($urandom_range(0, DEPTH));
      if ($urandom_range(0, 99) == 0) {ext_hyst, fifo_hyst} = 4'($urandom);
      c = int'(rx_count) + $urandom_range(0, 8) - 4;
      if (c < 0) c = 0;
      if (c > DEPTH) c = DEPTH;
      rx_count = CW'(c);
      step(auto_en ? "R3 R4 R5" : "R2");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule